// File: doc/BRIEF.md
# Parallel EPROM Program/Verify Target Controller

This block sits on the device side of a parallel programming link. It waits in an entry state until the test input is high, three mode inputs show the programming pattern and the high-byte port presents a jump code for long enough. After that it runs a small sequence. Two strobe inputs from an external programmer drive it: a step strobe and a program strobe. The sequence takes one starting address, then reads words back, advances through memory, and writes words through a write pulse that lasts as long as the program strobe is held.

Addresses and data are 16 bits wide. They travel over two byte ports, each with separate in, out and output-enable pins. The high byte uses one port and the low byte the other. The controller addresses a word-wide memory that sits outside it. A window of sixteen configuration locations is held inside the block as single bits. Writing to one of these locations clears its bit, and a read returns one byte of the configuration word. The clock is taken to be the instruction cycle. Every strobe and mode input crosses a two-stage synchronizer before any edge is detected.

Top module: `eprom_pgm_target`

## Requirements
- R1: The controller leaves the entry state only after test_i is high, mode_i equals 3'b100 and hi_i equals 8'hE1 for ENTRY_HOLD consecutive synchronized cycles. Strobes seen before that have no effect, and in particular the ports are not driven.
- R2: In the address-load state, the first rising edge of the step strobe latches {hi_i, lo_i} as the 16-bit address, with hi_i as the upper byte. The controller then goes to verify without driving the ports.
- R3: The first step pulse after an address load drives the word at that address for as long as the strobe stays high: bits 15:8 on hi_o and bits 7:0 on lo_o.
- R4: Each later step pulse in verify first increments the address and then drives the word at the new address.
- R5: Both output enables are high only during a verify read. Within 8 cycles of the step strobe falling they are low again, and they stay low during reset, entry, address load and programming.
- R6: A rising edge of the program strobe in verify starts a program cycle. SAMPLE_DLY cycles after the synchronized rise, {hi_i, lo_i} is sampled as write data. mem_we_o then stays high until the strobe's synchronized fall, which clears it within 8 cycles.
- R7: After a program cycle that ends with the step strobe low, a new program strobe pulse writes the same address again.
- R8: If the step strobe is high when the program strobe falls, the controller goes straight to a verify read of the same address, with no increment.
- R9: If the step strobe rises only after the program strobe has fallen, the address increments and the new word is read out.
- R10: A write to an address from 16'hFE00 to 16'hFE0F never asserts mem_we_o. Whatever the data, it clears configuration bit addr[3:0]. Configuration bits are all ones after reset and never go from 0 back to 1.
- R11: A read from the configuration window drives 8'hFF on hi_o. On lo_o it drives configuration bits 7:0 when addr[3] is 0, and bits 15:8 when addr[3] is 1.
- R12: Once the address is loaded, the port inputs never change it again. Only increments move it until the next reset.
- R13: A reset followed by a new entry returns the controller to address load, so a different address can be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low reset (device clear) |
| test_i | input | 1 | Test-mode request, asynchronous |
| mode_i | input | 3 | Entry pattern pins, asynchronous |
| strb_prog_i | input | 1 | Program strobe, asynchronous |
| strb_step_i | input | 1 | Step/read strobe, asynchronous |
| hi_i | input | 8 | High-byte port input |
| hi_o | output | 8 | High-byte port output |
| hi_oe_o | output | 1 | High-byte port output enable |
| lo_i | input | 8 | Low-byte port input |
| lo_o | output | 8 | Low-byte port output |
| lo_oe_o | output | 1 | Low-byte port output enable |
| mem_addr_o | output | 16 | Word address to memory |
| mem_rdata_i | input | 16 | Read word from memory |
| mem_wdata_o | output | 16 | Write word to memory |
| mem_we_o | output | 1 | Write pulse to memory |

## Verification
The hardest case is when the step strobe's rise and the program strobe's fall fall into the same program cycle. One signal decides whether the next read uses the same address or the next one. The bench raises the step strobe while the program strobe is still high. It then compares the word read back against the data just written, not against the following location. In a separate pass it raises the step strobe only after the fall and expects the next word instead. A second overlap is a write inside the configuration window: the same sampling cycle that would pulse memory must instead clear exactly one configuration bit. The bench counts write-pulse cycles and reads the configuration byte back to judge this.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    typedef enum logic [2:0] {
        ST_ENTRY  = 3'd0,
        ST_LOAD   = 3'd1,
        ST_VIDLE  = 3'd2,
        ST_VDRIVE = 3'd3,
        ST_PROG   = 3'd4,
        ST_PDONE  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[g] <= '0;
                    else        stg_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[g] <= '0;
                    else        stg_q[g] <= stg_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pgm_cfg_bits.sv
module pgm_cfg_bits #(
    parameter int IDX_W  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr_i,
    input  logic [IDX_W-1:0]                      idx_i,
    input  logic [IDX_W-$clog2(BYTE_W)-1:0]       sel_i,
    output logic [BYTE_W-1:0]                     byte_o
);
    localparam int CFG_N = 1 << IDX_W;

    logic [CFG_N-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (clr_i) cfg_d[idx_i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '1;
        else        cfg_q <= cfg_d;
    end

    assign byte_o = cfg_q[sel_i*BYTE_W +: BYTE_W];

    // R10: a programmed configuration bit never returns to the erased value
    assert_cfg_only_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cfg_q & ~$past(cfg_q)) == '0));
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
    import pgm_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          BYTE_W     = 8,
    parameter int          ENTRY_HOLD = 10,
    parameter int          SAMPLE_DLY = 3,
    parameter int          CFG_IDX_W  = 4,
    parameter logic [15:0] CFG_BASE   = 16'hFE00,
    parameter logic [7:0]  ENTRY_CODE = 8'hE1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 test_s,
    input  logic [2:0]           mode_s,
    input  logic                 s0_s,
    input  logic                 s1_s,
    input  logic [BYTE_W-1:0]    hi_in,
    input  logic [BYTE_W-1:0]    lo_in,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [2*BYTE_W-1:0]  wdata_o,
    output logic                 we_o,
    output logic                 drive_o,
    output logic                 cfg_clr_o,
    output logic [CFG_IDX_W-1:0] cfg_idx_o
);
    localparam int DATA_W = 2 * BYTE_W;
    localparam int CNT_MAX = (ENTRY_HOLD > SAMPLE_DLY) ? ENTRY_HOLD : SAMPLE_DLY;
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic                fresh;
        logic [CNT_W-1:0]    cnt;
        logic [DATA_W-1:0]   wdata;
        logic                we;
        logic                cfg_clr;
        logic                s0_prev;
        logic                s1_prev;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    logic s0_rise, s0_fall, s1_rise, s1_fall;
    logic entry_ok, in_cfg;

    always_comb begin
        s0_rise  = s0_s & ~r_q.s0_prev;
        s0_fall  = ~s0_s & r_q.s0_prev;
        s1_rise  = s1_s & ~r_q.s1_prev;
        s1_fall  = ~s1_s & r_q.s1_prev;
        entry_ok = test_s && (mode_s == 3'b100) && (hi_in == ENTRY_CODE);
        in_cfg   = (r_q.addr[ADDR_W-1:CFG_IDX_W] == CFG_BASE[ADDR_W-1:CFG_IDX_W]);

        r_d         = r_q;
        r_d.cfg_clr = 1'b0;
        r_d.s0_prev = s0_s;
        r_d.s1_prev = s1_s;

        case (r_q.st)
            ST_ENTRY: begin
                if (entry_ok) begin
                    if (r_q.cnt == CNT_W'(ENTRY_HOLD - 1)) begin
                        r_d.st  = ST_LOAD;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end else begin
                    r_d.cnt = '0;
                end
            end
            ST_LOAD: begin
                if (s1_rise) begin
                    r_d.addr  = {hi_in, lo_in};
                    r_d.fresh = 1'b1;
                    r_d.st    = ST_VIDLE;
                end
            end
            ST_VIDLE: begin
                if (s0_rise) begin
                    r_d.st  = ST_PROG;
                    r_d.cnt = '0;
                end else if (s1_rise) begin
                    if (!r_q.fresh) r_d.addr = r_q.addr + 1'b1;
                    r_d.fresh = 1'b0;
                    r_d.st    = ST_VDRIVE;
                end
            end
            ST_VDRIVE: begin
                if (s1_fall) r_d.st = ST_VIDLE;
            end
            ST_PROG: begin
                if (s0_fall) begin
                    r_d.we    = 1'b0;
                    r_d.fresh = 1'b0;
                    r_d.st    = s1_s ? ST_VDRIVE : ST_PDONE;
                end else if (r_q.cnt != CNT_W'(SAMPLE_DLY)) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(SAMPLE_DLY - 1)) begin
                        r_d.wdata = {hi_in, lo_in};
                        if (in_cfg) r_d.cfg_clr = 1'b1;
                        else        r_d.we      = 1'b1;
                    end
                end
            end
            ST_PDONE: begin
                if (s0_rise) begin
                    r_d.st  = ST_PROG;
                    r_d.cnt = '0;
                end else if (s1_rise) begin
                    r_d.addr = r_q.addr + 1'b1;
                    r_d.st   = ST_VDRIVE;
                end
            end
            default: r_d.st = ST_ENTRY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_ENTRY, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_o    = r_q.addr;
    assign wdata_o   = r_q.wdata;
    assign we_o      = r_q.we;
    assign drive_o   = (r_q.st == ST_VDRIVE);
    assign cfg_clr_o = r_q.cfg_clr;
    assign cfg_idx_o = r_q.addr[CFG_IDX_W-1:0];

    // R6: the write pulse exists only while the program strobe was seen high
    assert_we_within_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.we |-> r_q.s0_prev);

    // R7: the address does not move while a program cycle runs
    assert_addr_held_in_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PROG) |=> (r_q.addr == $past(r_q.addr)));

    // R12: after the load the address only holds or steps by one
    assert_addr_only_steps_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_ENTRY && r_q.st != ST_LOAD) |=>
        (r_q.addr == $past(r_q.addr) || r_q.addr == $past(r_q.addr) + 1'b1));

    // R1: nothing but entry happens until the pattern has been held
    assert_entry_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ENTRY) |-> (!r_q.we && !r_q.cfg_clr));
endmodule

// File: rtl/eprom_pgm_target.sv
module eprom_pgm_target #(
    parameter int          ADDR_W     = 16,
    parameter int          BYTE_W     = 8,
    parameter int          SYNC_STG   = 2,
    parameter int          ENTRY_HOLD = 10,
    parameter int          SAMPLE_DLY = 3,
    parameter int          CFG_IDX_W  = 4,
    parameter logic [15:0] CFG_BASE   = 16'hFE00,
    parameter logic [7:0]  ENTRY_CODE = 8'hE1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                test_i,
    input  logic [2:0]          mode_i,
    input  logic                strb_prog_i,
    input  logic                strb_step_i,
    input  logic [BYTE_W-1:0]   hi_i,
    output logic [BYTE_W-1:0]   hi_o,
    output logic                hi_oe_o,
    input  logic [BYTE_W-1:0]   lo_i,
    output logic [BYTE_W-1:0]   lo_o,
    output logic                lo_oe_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic [2*BYTE_W-1:0] mem_rdata_i,
    output logic [2*BYTE_W-1:0] mem_wdata_o,
    output logic                mem_we_o
);
    localparam int SYNC_W = 6;
    localparam int SEL_W  = CFG_IDX_W - $clog2(BYTE_W);

    logic [SYNC_W-1:0]    sync_s;
    logic                 drive;
    logic                 cfg_clr;
    logic [CFG_IDX_W-1:0] cfg_idx;
    logic [BYTE_W-1:0]    cfg_byte;
    logic                 addr_cfg;

    pgm_sync #(.W(SYNC_W), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({test_i, mode_i, strb_prog_i, strb_step_i}),
        .q_o   (sync_s)
    );

    pgm_seq #(
        .ADDR_W     (ADDR_W),
        .BYTE_W     (BYTE_W),
        .ENTRY_HOLD (ENTRY_HOLD),
        .SAMPLE_DLY (SAMPLE_DLY),
        .CFG_IDX_W  (CFG_IDX_W),
        .CFG_BASE   (CFG_BASE),
        .ENTRY_CODE (ENTRY_CODE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_s    (sync_s[5]),
        .mode_s    (sync_s[4:2]),
        .s0_s      (sync_s[1]),
        .s1_s      (sync_s[0]),
        .hi_in     (hi_i),
        .lo_in     (lo_i),
        .addr_o    (mem_addr_o),
        .wdata_o   (mem_wdata_o),
        .we_o      (mem_we_o),
        .drive_o   (drive),
        .cfg_clr_o (cfg_clr),
        .cfg_idx_o (cfg_idx)
    );

    pgm_cfg_bits #(.IDX_W(CFG_IDX_W), .BYTE_W(BYTE_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cfg_clr),
        .idx_i  (cfg_idx),
        .sel_i  (mem_addr_o[CFG_IDX_W-1 -: SEL_W]),
        .byte_o (cfg_byte)
    );

    always_comb begin
        addr_cfg = (mem_addr_o[ADDR_W-1:CFG_IDX_W] == CFG_BASE[ADDR_W-1:CFG_IDX_W]);
        hi_oe_o  = drive;
        lo_oe_o  = drive;
        if (addr_cfg) begin
            hi_o = '1;
            lo_o = cfg_byte;
        end else begin
            hi_o = mem_rdata_i[2*BYTE_W-1:BYTE_W];
            lo_o = mem_rdata_i[BYTE_W-1:0];
        end
    end

    // R5: the ports never drive while a write pulse is active
    assert_no_drive_while_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hi_oe_o |-> !mem_we_o);

    // R10: memory is never pulsed for a configuration location
    assert_cfg_no_mem_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o[ADDR_W-1:CFG_IDX_W] != CFG_BASE[ADDR_W-1:CFG_IDX_W]));
endmodule

// File: tb/eprom_pgm_target_bench.sv
module eprom_pgm_target_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 14;
    localparam int ENTRY_HOLD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_i = 1'b0;
    logic [2:0]  mode_i = 3'b000;
    logic        s0 = 1'b0;
    logic        s1 = 1'b0;
    logic [7:0]  hi_in = 8'h00;
    logic [7:0]  lo_in = 8'h00;
    logic [7:0]  hi_o, lo_o;
    logic        hi_oe, lo_oe;
    logic [15:0] mem_addr, mem_rdata, mem_wdata;
    logic        mem_we;

    logic [15:0] bmem [256];

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] hi;
        logic [7:0] lo;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eprom_pgm_target #(.ENTRY_HOLD(ENTRY_HOLD)) u_eprom_pgm_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_i      (test_i),
        .mode_i      (mode_i),
        .strb_prog_i (s0),
        .strb_step_i (s1),
        .hi_i        (hi_in),
        .hi_o        (hi_o),
        .hi_oe_o     (hi_oe),
        .lo_i        (lo_in),
        .lo_o        (lo_o),
        .lo_oe_o     (lo_oe),
        .mem_addr_o  (mem_addr),
        .mem_rdata_i (mem_rdata),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we)
    );

    function automatic logic [15:0] init_word(input logic [7:0] a);
        return {a ^ 8'h3C, a + 8'h11};
    endfunction

    assign mem_rdata = bmem[mem_addr[7:0]];

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = init_word(8'(i));
    end

    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    endtask

    // scoreboard monitor: pop one expected word per read burst
    int oe_run = 0;
    always @(negedge clk) begin
        if (hi_oe) oe_run++;
        else       oe_run = 0;
        if (oe_run == 4) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R5 unexpected port drive", {16'h0, hi_o, lo_o}, 32'h0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk({hi_o, lo_o} == {e.hi, e.lo} && lo_oe, e.tag,
                    {15'h0, lo_oe, hi_o, lo_o}, {16'h1, e.hi, e.lo});
            end
        end
    end

    task automatic expect_word(input logic [15:0] w, input string tag);
        exp_t e;
        e.hi = w[15:8];
        e.lo = w[7:0];
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic step_pulse(output int oecnt);
        oecnt = 0;
        s1 = 1'b1;
        repeat (HOLD) begin
            @(negedge clk);
            if (hi_oe) oecnt++;
        end
        s1 = 1'b0;
        repeat (8) @(negedge clk);
        chk(!hi_oe && !lo_oe, "R5 release after step fall", {31'h0, hi_oe}, 32'h0);
        repeat (HOLD - 8) @(negedge clk);
    endtask

    // mode 0: no step, 1: step rises before program strobe falls, 2: step after fall
    task automatic prog_word(input logic [15:0] d, input int mode, output int wecnt, output int oecnt);
        int dummy;
        wecnt = 0;
        oecnt = 0;
        hi_in = d[15:8];
        lo_in = d[7:0];
        @(negedge clk);
        s0 = 1'b1;
        repeat (HOLD) begin
            @(negedge clk);
            if (mem_we) wecnt++;
            if (hi_oe) oecnt++;
        end
        if (mode == 1) begin
            s1 = 1'b1;
            repeat (6) @(negedge clk);
            s0 = 1'b0;
            repeat (HOLD) @(negedge clk);
            chk(!mem_we, "R6 write pulse ends", {31'h0, mem_we}, 32'h0);
            s1 = 1'b0;
            repeat (HOLD) @(negedge clk);
        end else begin
            s0 = 1'b0;
            repeat (8) @(negedge clk);
            chk(!mem_we, "R6 write pulse ends", {31'h0, mem_we}, 32'h0);
            repeat (HOLD - 8) @(negedge clk);
            if (mode == 2) step_pulse(dummy);
        end
    endtask

    task automatic enter_mode();
        rst_n = 1'b0;
        s0 = 1'b0;
        s1 = 1'b0;
        test_i = 1'b1;
        mode_i = 3'b100;
        hi_in = 8'hE1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (ENTRY_HOLD + 6) @(negedge clk);
    endtask

    task automatic load_addr(input logic [15:0] a);
        int oc;
        hi_in = a[15:8];
        lo_in = a[7:0];
        step_pulse(oc);
        chk(oc == 0, "R2 no drive during address load", oc, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin : stim
        int oc, wc;

        repeat (3) @(negedge clk);
        chk(!hi_oe && !lo_oe, "R5 ports off in reset", {30'h0, hi_oe, lo_oe}, 0);
        chk(!mem_we, "R5 no write in reset", {31'h0, mem_we}, 0);

        // R1: a short code does not enter; strobes before entry do nothing
        test_i = 1'b1;
        mode_i = 3'b100;
        hi_in = 8'hE1;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        hi_in = 8'h00;
        lo_in = 8'h10;
        step_pulse(oc);
        chk(oc == 0, "R1 short code ignored", oc, 0);
        chk(!mem_we, "R1 no write before entry", {31'h0, mem_we}, 0);
        hi_in = 8'hE1;
        repeat (ENTRY_HOLD + 6) @(negedge clk);

        load_addr(16'h0010);
        hi_in = 8'hAB;
        lo_in = 8'hCD;
        expect_word(init_word(8'h10), "R3 first read at loaded address");
        step_pulse(oc);
        expect_word(init_word(8'h11), "R4 increment then read");
        step_pulse(oc);
        expect_word(init_word(8'h11), "R12 port values do not reload address");
        sbq.delete(sbq.size() - 1);
        chk(sbq.size() == 0, "R12 reads consumed in order", sbq.size(), 0);

        prog_word(16'hBEEF, 0, wc, oc);
        chk(bmem[8'h11] == 16'hBEEF, "R6 write data stored", bmem[8'h11], 16'hBEEF);
        chk(wc > 0 && wc <= HOLD - 3, "R6 write pulse delayed after strobe", wc, HOLD - 3);
        chk(oc == 0, "R5 no drive while programming", oc, 0);

        prog_word(16'h1234, 0, wc, oc);
        chk(bmem[8'h11] == 16'h1234, "R7 same address reprogrammed", bmem[8'h11], 16'h1234);
        chk(bmem[8'h12] == init_word(8'h12), "R7 next address untouched", bmem[8'h12], init_word(8'h12));

        expect_word(init_word(8'h12), "R9 step after program increments");
        step_pulse(oc);

        expect_word(16'h4321, "R8 step before fall reads same address");
        prog_word(16'h4321, 1, wc, oc);
        chk(bmem[8'h12] == 16'h4321, "R8 write landed", bmem[8'h12], 16'h4321);

        expect_word(init_word(8'h13), "R4 continue after in-place read");
        step_pulse(oc);

        // R13: reset and re-entry accept a new address
        enter_mode();
        load_addr(16'h0005);
        expect_word(init_word(8'h05), "R13 new address after re-entry");
        step_pulse(oc);

        // configuration window
        enter_mode();
        load_addr(16'hFE00);
        expect_word(16'hFFFF, "R11 erased config low byte");
        step_pulse(oc);
        expect_word(16'hFFFE, "R10 write clears bit 0");
        prog_word(16'hFFFF, 1, wc, oc);
        chk(wc == 0, "R10 no memory write for config", wc, 0);
        expect_word(16'hFFFE, "R11 FE01 reads low byte");
        step_pulse(oc);
        expect_word(16'hFFFC, "R10 bit 1 cleared, data ignored");
        prog_word(16'h0000, 2, wc, oc);
        chk(wc == 0, "R10 no memory write for config", wc, 0);
        for (int k = 3; k < 8; k++) begin
            expect_word(16'hFFFC, "R11 low byte in lower half");
            step_pulse(oc);
        end
        expect_word(16'hFFFF, "R11 high byte at FE08");
        step_pulse(oc);
        expect_word(16'hFFFE, "R10 bit 8 cleared");
        prog_word(16'h1357, 1, wc, oc);
        expect_word(16'hFFFE, "R11 high byte at FE09");
        step_pulse(oc);
        chk(bmem[8'h00] == init_word(8'h00), "R10 aliased memory untouched", bmem[8'h00], init_word(8'h00));

        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R3 all expected reads observed", sbq.size(), 0);
        summary();
    end
endmodule